// File: doc/BRIEF.md
# Isolated Channel Output State Controller

This block decides what each receive-side output of a one-directional isolated link drives: the channel data, a fixed fail-safe level, a forced low, or nothing (tri-state). It watches two supply readings, one for the transmitting side and one for the receiving side. Each reading arrives as a sampled millivolt code. Each side has its own undervoltage lockout with hysteresis and its own startup hold timer. These side states, an output-enable code with a pull-up meaning, and the channel data are combined into a single drive decision that applies to every channel at once.

Channel data are level signals that the block samples on every clock. It has no valid/ready handshake and applies no back-pressure, because a channel never waits and never drops a value. It simply follows the input through a two-stage synchronizer and one output register. Build-time parameters set the channel count (three to six), the lockout thresholds, the startup hold length in cycles, the fail-safe level, and whether the enable pin exists at all.

Top module: `iso_out_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `ch_oe` and `ch_out` are all zero. Both sides begin in lockout with their hold timers cleared.
- R2: A side in lockout leaves it on the first clock whose supply code is strictly above `RISE_MV` (default 2800). A side out of lockout enters lockout on the first clock whose code is strictly below `FALL_MV` (default 2500). Codes between the two thresholds, and codes exactly equal to either, leave the state unchanged.
- R3: A side becomes ready only after it has been out of lockout for `START_CYCLES` consecutive clocks. Any return to lockout, even for one clock, clears the hold timer, so the full interval starts again.
- R4: While the receive side is in lockout, every `ch_oe` bit is 0 and every `ch_out` bit is 0.
- R5: While the receive side is out of lockout but not yet ready, and enable is active, every channel drives low (`ch_oe` all ones, `ch_out` all zero).
- R6: With `HAS_ENABLE`=1, the enable code 2'b00 (driven low) forces every output to tri-state (`ch_oe`=0, `ch_out`=0). This holds whatever the data and the transmit-side state are, including during the receive-side hold.
- R7: The enable codes 2'b01 (driven high), 2'b10 (unconnected, pulled up) and 2'b11 (reserved) all count as active.
- R8: When both sides are ready and enable is active, `ch_oe` is all ones. Each `ch_out` bit then equals the value its `ch_in` bit had at a rising edge, starting from the output change that follows the second edge after that one.
- R9: When the receive side is ready, the transmit side is in lockout or still in its hold, and enable is active, every channel drives the fail-safe level: all ones if `DEFAULT_HIGH`=1, all zeros otherwise, with `ch_oe` all ones.
- R10: With `HAS_ENABLE`=0, `en_code` has no effect and the block behaves as if enable were always active.
- R11: The output-enable bits always move together: `ch_oe` is either all zeros or all ones.
- R12: Every state change reaches the outputs one clock after the side state or enable that causes it is registered. A supply crossing therefore shows on the outputs after the second edge following the sample that crossed, and an enable change shows after the first edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive-side clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_in | input | NUM_CH | Latched channel data from the transmit side |
| en_code | input | 2 | Enable pin state: 00 low, 01 high, 10 unconnected, 11 reserved |
| vdd_in_mv | input | SUPPLY_W | Transmit-side supply reading in millivolts |
| vdd_out_mv | input | SUPPLY_W | Receive-side supply reading in millivolts |
| ch_out | output | NUM_CH | Registered channel output value |
| ch_oe | output | NUM_CH | Registered per-channel output drive enable (0 = tri-state) |

## Verification
The bench places supply codes exactly on each threshold and one millivolt beyond it. A design that compared with the wrong inequality would leave or enter lockout one code early, and the hysteresis band would collapse. A one-clock dip into lockout in the middle of a hold must restart the full interval; a timer that only paused would release the fail-safe level to live data several cycles too soon. Enable is pulled low while the receive side is still in its hold, and this must win over the forced-low drive. A second instance with no enable pin and a high fail-safe level must ignore the enable code and show all-ones while the transmit side is down, so a swapped priority or an inverted default level shows at once. Random channel data runs through every phase, so any mistake in the three-edge data latency shows as a miscompare on every changing bit.

// File: rtl/iso_ctrl_pkg.sv
package iso_ctrl_pkg;

  typedef enum logic [1:0] {
    EN_DRIVE_LOW  = 2'b00,
    EN_DRIVE_HIGH = 2'b01,
    EN_OPEN       = 2'b10,
    EN_RSVD       = 2'b11
  } en_code_e;

  typedef enum logic [1:0] {
    MODE_OFF      = 2'd0,
    MODE_HOLD_LOW = 2'd1,
    MODE_FAILSAFE = 2'd2,
    MODE_PASS     = 2'd3
  } drive_mode_e;

  // Unconnected and reserved codes resolve to active through the pull-up.
  function automatic logic en_asserted(input logic [1:0] code);
    return code != EN_DRIVE_LOW;
  endfunction

endpackage

// File: rtl/iso_supply_side.sv
module iso_supply_side #(
  parameter int SUPPLY_W     = 13,
  parameter int RISE_MV      = 2800,
  parameter int FALL_MV      = 2500,
  parameter int START_CYCLES = 40
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SUPPLY_W-1:0] supply_mv,
  output logic                locked,
  output logic                ready
);

  localparam int CNT_W = (START_CYCLES < 1) ? 1 : $clog2(START_CYCLES + 1);
  localparam logic [CNT_W-1:0]    CNT_DONE  = CNT_W'(START_CYCLES);
  localparam logic [SUPPLY_W-1:0] RISE_CODE = SUPPLY_W'(RISE_MV);
  localparam logic [SUPPLY_W-1:0] FALL_CODE = SUPPLY_W'(FALL_MV);

  logic             locked_q;
  logic [CNT_W-1:0] hold_cnt_q;
  logic             above_rise;
  logic             below_fall;

  assign above_rise = supply_mv > RISE_CODE;
  assign below_fall = supply_mv < FALL_CODE;

  // Lockout flag with hysteresis: exit needs the upper threshold, entry the lower.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b1;
    end else if (locked_q) begin
      locked_q <= !above_rise;
    end else begin
      locked_q <= below_fall;
    end
  end

  // Startup hold timer, cleared by every lockout cycle, saturating at the limit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_cnt_q <= '0;
    end else if (locked_q) begin
      hold_cnt_q <= '0;
    end else if (hold_cnt_q != CNT_DONE) begin
      hold_cnt_q <= hold_cnt_q + 1'b1;
    end
  end

  assign locked = locked_q;
  assign ready  = !locked_q && (hold_cnt_q == CNT_DONE);

  // R2: inside the band (or at the upper threshold) a locked side stays locked
  assert_stay_locked_R2: assert property (
    @(posedge clk) disable iff (!rst_n)
    (locked_q && supply_mv <= RISE_CODE) |=> locked_q
  );

  // R2: at or above the lower threshold an active side stays active
  assert_stay_active_R2: assert property (
    @(posedge clk) disable iff (!rst_n)
    (!locked_q && supply_mv >= FALL_CODE) |=> !locked_q
  );

  // R3: a lockout cycle always withdraws readiness on the next cycle
  assert_hold_restart_R3: assert property (
    @(posedge clk) disable iff (!rst_n)
    locked_q |=> !ready
  );

  // R3: readiness is only reached from an unlocked cycle
  assert_ready_entry_R3: assert property (
    @(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> !$past(locked_q)
  );

endmodule

// File: rtl/iso_chan_sync.sv
module iso_chan_sync #(
  parameter int NUM_CH = 6,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] din,
  output logic [NUM_CH-1:0] dout
);

  logic [NUM_CH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/iso_drive_select.sv
module iso_drive_select
  import iso_ctrl_pkg::*;
#(
  parameter int NUM_CH       = 6,
  parameter bit DEFAULT_HIGH = 1'b0,
  parameter bit HAS_ENABLE   = 1'b1
) (
  input  logic [1:0]        en_code,
  input  logic              in_ready,
  input  logic              out_locked,
  input  logic              out_ready,
  input  logic [NUM_CH-1:0] data,
  output logic [NUM_CH-1:0] nxt_oe,
  output logic [NUM_CH-1:0] nxt_out
);

  logic        en_on;
  drive_mode_e mode;

  if (HAS_ENABLE) begin : g_enable_pin
    assign en_on = en_asserted(en_code);
  end else begin : g_no_enable_pin
    assign en_on = 1'b1;
  end

  // Priority: receive-side lockout, then enable, then receive hold, then transmit side.
  always_comb begin
    if (out_locked)      mode = MODE_OFF;
    else if (!en_on)     mode = MODE_OFF;
    else if (!out_ready) mode = MODE_HOLD_LOW;
    else if (!in_ready)  mode = MODE_FAILSAFE;
    else                 mode = MODE_PASS;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    always_comb begin
      unique case (mode)
        MODE_OFF:      begin nxt_oe[c] = 1'b0; nxt_out[c] = 1'b0;         end
        MODE_HOLD_LOW: begin nxt_oe[c] = 1'b1; nxt_out[c] = 1'b0;         end
        MODE_FAILSAFE: begin nxt_oe[c] = 1'b1; nxt_out[c] = DEFAULT_HIGH; end
        MODE_PASS:     begin nxt_oe[c] = 1'b1; nxt_out[c] = data[c];      end
        default:       begin nxt_oe[c] = 1'b0; nxt_out[c] = 1'b0;         end
      endcase
    end
  end

endmodule

// File: rtl/iso_out_ctrl.sv
module iso_out_ctrl
  import iso_ctrl_pkg::*;
#(
  parameter int NUM_CH       = 6,
  parameter int SUPPLY_W     = 13,
  parameter int RISE_MV      = 2800,
  parameter int FALL_MV      = 2500,
  parameter int START_CYCLES = 40,
  parameter bit DEFAULT_HIGH = 1'b0,
  parameter bit HAS_ENABLE   = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_CH-1:0]   ch_in,
  input  logic [1:0]          en_code,
  input  logic [SUPPLY_W-1:0] vdd_in_mv,
  input  logic [SUPPLY_W-1:0] vdd_out_mv,
  output logic [NUM_CH-1:0]   ch_out,
  output logic [NUM_CH-1:0]   ch_oe
);

  localparam int SYNC_STAGES = 2;
  localparam logic [NUM_CH-1:0] FAILSAFE_WORD = DEFAULT_HIGH ? '1 : '0;

  logic              in_locked, in_ready;
  logic              out_locked, out_ready;
  logic [NUM_CH-1:0] data_sync;
  logic [NUM_CH-1:0] nxt_oe, nxt_out;
  logic [NUM_CH-1:0] ch_out_q, ch_oe_q;

  iso_supply_side #(
    .SUPPLY_W(SUPPLY_W), .RISE_MV(RISE_MV), .FALL_MV(FALL_MV), .START_CYCLES(START_CYCLES)
  ) u_tx_side (
    .clk(clk), .rst_n(rst_n), .supply_mv(vdd_in_mv), .locked(in_locked), .ready(in_ready)
  );

  iso_supply_side #(
    .SUPPLY_W(SUPPLY_W), .RISE_MV(RISE_MV), .FALL_MV(FALL_MV), .START_CYCLES(START_CYCLES)
  ) u_rx_side (
    .clk(clk), .rst_n(rst_n), .supply_mv(vdd_out_mv), .locked(out_locked), .ready(out_ready)
  );

  iso_chan_sync #(.NUM_CH(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(ch_in), .dout(data_sync)
  );

  iso_drive_select #(
    .NUM_CH(NUM_CH), .DEFAULT_HIGH(DEFAULT_HIGH), .HAS_ENABLE(HAS_ENABLE)
  ) u_select (
    .en_code(en_code), .in_ready(in_ready), .out_locked(out_locked), .out_ready(out_ready),
    .data(data_sync), .nxt_oe(nxt_oe), .nxt_out(nxt_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_out_q <= '0;
      ch_oe_q  <= '0;
    end else begin
      ch_out_q <= nxt_out;
      ch_oe_q  <= nxt_oe;
    end
  end

  assign ch_out = ch_out_q;
  assign ch_oe  = ch_oe_q;

  logic chk_en_active;
  assign chk_en_active = !HAS_ENABLE || (en_code != 2'b00);

  // R11: drive enables never split across channels
  assert_uniform_oe_R11: assert property (
    @(posedge clk) disable iff (!rst_n)
    (ch_oe_q == '0) || (ch_oe_q == '1)
  );

  // R4: receive-side lockout darkens every output on the next cycle
  assert_dark_output_R4: assert property (
    @(posedge clk) disable iff (!rst_n)
    out_locked |=> (ch_oe_q == '0 && ch_out_q == '0)
  );

  // R6: a low enable code tri-states everything on the next cycle
  assert_enable_low_R6: assert property (
    @(posedge clk) disable iff (!rst_n)
    (HAS_ENABLE && en_code == 2'b00) |=> (ch_oe_q == '0)
  );

  // R9: lost transmit side with a ready receive side yields the fail-safe word
  assert_failsafe_R9: assert property (
    @(posedge clk) disable iff (!rst_n)
    (out_ready && !in_ready && chk_en_active) |=> (ch_oe_q == '1 && ch_out_q == FAILSAFE_WORD)
  );

  // R8: with both sides ready the output carries the input from three samples back
  assert_pass_latency_R8: assert property (
    @(posedge clk) disable iff (!rst_n)
    (out_ready && in_ready && chk_en_active) |=> (ch_out_q == $past(ch_in, 3))
  );

endmodule

// File: tb/iso_out_ctrl_tb.sv
`timescale 1ns/100ps
module iso_out_ctrl_tb;

  localparam int ST0 = 8;
  localparam int ST1 = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  ch_in = '0;
  logic [1:0]  en_code = 2'b01;
  logic [12:0] vdd_in_mv = '0;
  logic [12:0] vdd_out_mv = '0;
  logic [5:0]  a_out, a_oe;
  logic [2:0]  b_out, b_oe;

  always #2.5 clk = ~clk;

  iso_out_ctrl #(.NUM_CH(6), .SUPPLY_W(13), .START_CYCLES(ST0), .DEFAULT_HIGH(1'b0), .HAS_ENABLE(1'b1))
  u_dut (
    .clk(clk), .rst_n(rst_n), .ch_in(ch_in), .en_code(en_code),
    .vdd_in_mv(vdd_in_mv), .vdd_out_mv(vdd_out_mv), .ch_out(a_out), .ch_oe(a_oe)
  );

  iso_out_ctrl #(.NUM_CH(3), .SUPPLY_W(13), .START_CYCLES(ST1), .DEFAULT_HIGH(1'b1), .HAS_ENABLE(1'b0))
  u_dut_fixed (
    .clk(clk), .rst_n(rst_n), .ch_in(ch_in[2:0]), .en_code(en_code),
    .vdd_in_mv(vdd_in_mv), .vdd_out_mv(vdd_out_mv), .ch_out(b_out), .ch_oe(b_oe)
  );

  int    vectors = 0;
  int    miscompares = 0;
  int    cycles = 0;
  bit    running = 1'b0;
  bit    done = 1'b0;
  string cur_req = "R1";

  // Channel data source: pseudo-random or a fixed pattern.
  bit       wiggle = 1'b0;
  logic [5:0] fixed_pat = '0;
  logic [7:0] lfsr = 8'hA5;
  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    ch_in <= wiggle ? lfsr[5:0] : fixed_pat;
  end

  function automatic int st_of(input int i);
    return (i == 0) ? ST0 : ST1;
  endfunction
  function automatic int nch_of(input int i);
    return (i == 0) ? 6 : 3;
  endfunction

  // Behavioural reference: per instance, side flags and hold counts as integers.
  int         m_li [2];
  int         m_ci [2];
  int         m_lo [2];
  int         m_co [2];
  logic [5:0] e_oe [2];
  logic [5:0] e_out[2];
  logic [5:0] d_q[$];
  logic [5:0] msk;
  bit         in_ok, out_ok, en_ok, fs_high;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        m_li[i] = 1; m_ci[i] = 0; m_lo[i] = 1; m_co[i] = 0;
        e_oe[i] = '0; e_out[i] = '0;
      end
      d_q = '{6'd0, 6'd0};
    end else begin
      for (int i = 0; i < 2; i++) begin
        msk     = 6'h3f >> (6 - nch_of(i));
        in_ok   = (m_li[i] == 0) && (m_ci[i] == st_of(i));
        out_ok  = (m_lo[i] == 0) && (m_co[i] == st_of(i));
        en_ok   = (i == 1) || (en_code != 2'b00);
        fs_high = (i == 1);
        if (m_lo[i] != 0)  begin e_oe[i] = '0;  e_out[i] = '0; end
        else if (!en_ok)   begin e_oe[i] = '0;  e_out[i] = '0; end
        else if (!out_ok)  begin e_oe[i] = msk; e_out[i] = '0; end
        else if (!in_ok)   begin e_oe[i] = msk; e_out[i] = fs_high ? msk : 6'd0; end
        else               begin e_oe[i] = msk; e_out[i] = d_q[0] & msk; end
        m_ci[i] = (m_li[i] != 0) ? 0 : ((m_ci[i] < st_of(i)) ? m_ci[i] + 1 : m_ci[i]);
        m_co[i] = (m_lo[i] != 0) ? 0 : ((m_co[i] < st_of(i)) ? m_co[i] + 1 : m_co[i]);
        if (m_li[i] != 0) m_li[i] = (vdd_in_mv <= 13'd2800) ? 1 : 0;
        else              m_li[i] = (vdd_in_mv <  13'd2500) ? 1 : 0;
        if (m_lo[i] != 0) m_lo[i] = (vdd_out_mv <= 13'd2800) ? 1 : 0;
        else              m_lo[i] = (vdd_out_mv <  13'd2500) ? 1 : 0;
      end
      void'(d_q.pop_front());
      d_q.push_back(ch_in);
    end
  end

  // Per-cycle comparison away from the active edge.
  always @(negedge clk) begin
    if (running) begin
      vectors++;
      if (a_oe !== e_oe[0] || a_out !== e_out[0]) begin
        miscompares++;
        $display("FAIL %s u_dut: oe=%b out=%b expected oe=%b out=%b", cur_req, a_oe, a_out, e_oe[0], e_out[0]);
      end
      vectors++;
      if ({3'b000, b_oe} !== e_oe[1] || {3'b000, b_out} !== e_out[1]) begin
        miscompares++;
        $display("FAIL %s u_dut_fixed: oe=%b out=%b expected oe=%b out=%b", cur_req, b_oe, b_out, e_oe[1][2:0], e_out[1][2:0]);
      end
    end
  end

  task automatic check_direct(input string req, input logic [5:0] act, input logic [5:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s direct: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      miscompares++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    cyc(4);
    running = 1'b1;
    check_direct("R1", a_oe, 6'h00);
    check_direct("R1", a_out, 6'h00);
    rst_n = 1'b1;
    cyc(1);
    check_direct("R1", {3'b000, b_oe}, 6'h00);
    cyc(2);
    cur_req = "R4";
    check_direct("R4", a_oe, 6'h00);

    // R5: receive side powers up, hold drives low
    wiggle = 1'b1;
    cur_req = "R5";
    vdd_out_mv = 13'd3300;
    cyc(3);
    check_direct("R5", a_oe, 6'h3f);
    check_direct("R5", a_out, 6'h00);

    // R9: receive ready, transmit still down
    cyc(12);
    cur_req = "R9";
    check_direct("R9", a_out, 6'h00);
    check_direct("R9", {3'b000, b_out}, 6'h07);

    // R8: transmit side up, data follows
    cur_req = "R8";
    vdd_in_mv = 13'd3300;
    cyc(30);
    wiggle = 1'b0;
    fixed_pat = 6'h2d;
    cyc(5);
    check_direct("R8", a_out, 6'h2d);
    fixed_pat = 6'h12;
    cyc(5);
    check_direct("R8", a_out, 6'h12);
    check_direct("R8", {3'b000, b_out}, 6'h02);
    wiggle = 1'b1;

    // R2: band and exact thresholds
    cur_req = "R2";
    vdd_in_mv = 13'd2600; cyc(8);
    vdd_in_mv = 13'd2500; cyc(6);
    check_direct("R2", {3'b000, b_oe}, 6'h07);
    vdd_in_mv = 13'd2499; cyc(3);
    check_direct("R9", {3'b000, b_out}, 6'h07);
    vdd_in_mv = 13'd2700; cyc(6);
    vdd_in_mv = 13'd2800; cyc(6);
    check_direct("R2", {3'b000, b_out}, 6'h07);

    // R3: hold interrupted by a single-cycle dip restarts
    cur_req = "R3";
    vdd_in_mv = 13'd2801; cyc(5);
    vdd_in_mv = 13'd2000; cyc(1);
    vdd_in_mv = 13'd3000; cyc(6);
    check_direct("R3", {3'b000, b_out}, 6'h07);
    cyc(10);

    // R6 / R10 / R7: enable codes
    cur_req = "R6";
    en_code = 2'b00; cyc(3);
    check_direct("R6", a_oe, 6'h00);
    cur_req = "R10";
    check_direct("R10", {3'b000, b_oe}, 6'h07);
    cyc(4);
    cur_req = "R7";
    en_code = 2'b10; cyc(3);
    check_direct("R7", a_oe, 6'h3f);
    en_code = 2'b11; cyc(6);
    check_direct("R7", a_oe, 6'h3f);
    en_code = 2'b01; cyc(4);

    // R4: receive side lost, then returns with enable low
    cur_req = "R4";
    vdd_out_mv = 13'd2000; cyc(3);
    check_direct("R4", a_oe, 6'h00);
    check_direct("R4", {3'b000, b_oe}, 6'h00);
    cur_req = "R6";
    en_code = 2'b00;
    vdd_out_mv = 13'd3300; cyc(4);
    check_direct("R6", a_oe, 6'h00);
    check_direct("R5", {3'b000, b_oe}, 6'h07);
    cyc(12);
    cur_req = "R12";
    en_code = 2'b01; cyc(2);
    check_direct("R12", a_oe, 6'h3f);
    cur_req = "R11";
    cyc(20);

    running = 1'b0;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule